// File: doc/BRIEF.md
# Brightness PWM Dimming Decoder

This block turns an external brightness PWM waveform into the two controls that a bank of LED current sinks needs: a 10-bit amplitude code, expressed as a fraction of the sinks' full-scale current, and one on/off gate shared by every sink. It synchronizes the input with two flops. It counts the high time and the period of each input cycle in system clocks, and converts their ratio into a duty code with a short bit-serial divider. A 2-bit mode input then selects how that duty code is applied. In direct mode the sinks are chopped at full amplitude in step with the input. In analog mode the sinks stay on and the amplitude follows the duty. In mixed mode the amplitude follows the duty down to one quarter of full scale, and below that point the amplitude is held at one quarter while the sinks are chopped.

A separate ready output starts the boost ramp of the regulator. In direct mode it rises with the first synchronized rising edge. In the other modes it waits for two complete measured periods and for a minimum time after the first edge, whichever comes later. If the input rises once and then stays high, a timeout asserts ready at full duty. Before ready, the sinks are held off at zero amplitude.

All outputs are plain level signals with no handshake. Inside the block, the period meter passes each finished measurement to the divider over a valid/ready pair. The meter holds valid until the divider is idle. If a new period closes while a measurement is still waiting, the newer one replaces it. Periods shorter than about a dozen clocks therefore lose measurements and do not stall anything.

Top module: `bdim_decoder`

## Requirements
- R1: With mode 00 (direct), once ready, sink_gate equals the input delayed by two clocks, amp_code is 1023, and ramp_ready rises in the same cycle as the first synchronized rising edge.
- R2: With mode 01 (mixed), when the duty code is 256 or more, sink_gate stays high for the whole period and amp_code equals the duty code.
- R3: With mode 01, when the duty code is below 256, amp_code is 256 and sink_gate follows the two-clock-delayed input.
- R4: With mode 10 (analog), once ready, sink_gate stays high and amp_code is the duty code, raised to 10 (one percent of 1023) when the code is smaller.
- R5: The duty code is floor(high_clocks * 1024 / period_clocks). Both quantities are counted between synchronized edges, and a constant-high input maps to 1023.
- R6: In modes 01, 10 and 11, ramp_ready rises only after two measured periods have completed and at least MIN_DELAY_CYC clocks have passed since the first rising edge. Once high, ramp_ready stays high until reset.
- R7: Before ramp_ready rises, including while the input stays low with no edge at all, sink_gate is 0 and amp_code is 0.
- R8: If the input stays high for STUCK_HIGH_CYC clocks after a rising edge, the duty code becomes 1023 and ramp_ready rises.
- R9: Mode 11 behaves exactly as mode 01.
- R10: amp_code and the gate/chop decision change only when a new measurement completes, which happens a fixed number of clocks after the rising edge that closes a period. They never change in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all counting is in these cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Asynchronous brightness PWM waveform |
| dim_mode | input | 2 | Dimming mode: 00 direct, 01 mixed, 10 analog, 11 same as mixed |
| amp_code | output | DUTY_W | Sink amplitude as a fraction of full scale (1023 = full) |
| sink_gate | output | 1 | Common on/off enable for all current sinks |
| ramp_ready | output | 1 | Decode complete; starts the boost ramp |

## Verification
The bench builds the block with a 12-bit period counter, a 200-clock minimum decode delay and a 1500-clock stuck-high timeout. With these values, each limit of the ready logic is reached within a few hundred or a few thousand clocks. With 100-clock periods, every integer high time from 1 to 96 is swept in mixed and analog modes. This sweep covers both sides of the quarter-scale switch point (codes 245 and 256). A 200-clock period with a one-clock pulse pushes the analog code below the one-percent floor. One case uses 40-clock periods and another uses 150-clock periods, so each of the two delay conditions is the one that decides when ready rises.

// File: rtl/bdim_pkg.sv
package bdim_pkg;
  typedef enum logic [1:0] {
    DIM_DIRECT = 2'b00,
    DIM_MIXED  = 2'b01,
    DIM_ANALOG = 2'b10,
    DIM_RSVD   = 2'b11
  } dim_mode_e;

  // The reserved encoding falls back to mixed dimming.
  function automatic dim_mode_e canon_mode(dim_mode_e m);
    return (m == DIM_RSVD) ? DIM_MIXED : m;
  endfunction
endpackage

// File: rtl/bdim_sync.sv
module bdim_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], async_in};
  end

  // Edge flags look one stage ahead, so they coincide with the cycle
  // before level changes and registered users line up with level.
  assign level = stg_q[1];
  assign rise  = stg_q[0] & ~stg_q[1];
  assign fall  = ~stg_q[0] & stg_q[1];
endmodule

// File: rtl/bdim_meter.sv
module bdim_meter #(
  parameter int CNT_W     = 21,
  parameter int STUCK_CYC = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  logic             rise,
  input  logic             fall,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [CNT_W-1:0] m_period,
  output logic [CNT_W-1:0] m_high,
  output logic             stuck_pulse
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam bit               STUCK_EN = (STUCK_CYC < 2**CNT_W);
  localparam logic [CNT_W-1:0] STUCK_AT = CNT_W'(STUCK_CYC);

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] high_q;
  logic             armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt     <= '0;
      high_q      <= '0;
      armed_q     <= 1'b0;
      m_valid     <= 1'b0;
      m_period    <= '0;
      m_high      <= '0;
      stuck_pulse <= 1'b0;
    end else begin
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (rise) begin
        // Closing edge of a period: publish the pair, newest wins.
        run_cnt <= CNT_W'(1);
        armed_q <= 1'b1;
        if (armed_q) begin
          m_valid  <= 1'b1;
          m_period <= run_cnt;
          m_high   <= high_q;
        end
      end else if (run_cnt != CNT_MAX) begin
        run_cnt <= run_cnt + 1'b1;
      end
      if (fall) high_q <= run_cnt;
      stuck_pulse <= STUCK_EN && armed_q && level && !rise && (run_cnt == STUCK_AT);
    end
  end
endmodule

// File: rtl/bdim_divider.sv
module bdim_divider #(
  parameter int CNT_W = 21,
  parameter int Q_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CNT_W-1:0] in_period,
  input  logic [CNT_W-1:0] in_high,
  output logic             out_valid,
  output logic [Q_W-1:0]   out_code
);
  localparam int             STEP_W = $clog2(Q_W + 1);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(Q_W - 1);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0]  rem_q;
  logic [CNT_W-1:0]  den_q;
  logic [Q_W-1:0]    quo_q;
  logic [CNT_W:0]    dbl;
  logic [CNT_W-1:0]  diff;
  logic              take;
  logic [Q_W-1:0]    quo_nxt;

  // One restoring step per clock; remainder never exceeds the divisor.
  always_comb begin
    dbl     = {rem_q, 1'b0};
    take    = (dbl >= {1'b0, den_q});
    diff    = dbl[CNT_W-1:0] - den_q;
    quo_nxt = {quo_q[Q_W-2:0], take};
  end

  assign in_ready = !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      step_q    <= '0;
      rem_q     <= '0;
      den_q     <= '0;
      quo_q     <= '0;
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (!busy_q) begin
        if (in_valid) begin
          busy_q <= 1'b1;
          rem_q  <= in_high;
          den_q  <= in_period;
          step_q <= '0;
          quo_q  <= '0;
        end
      end else begin
        rem_q  <= take ? diff : dbl[CNT_W-1:0];
        quo_q  <= quo_nxt;
        step_q <= step_q + 1'b1;
        if (step_q == LAST) begin
          busy_q    <= 1'b0;
          out_valid <= 1'b1;
          out_code  <= quo_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/bdim_ready.sv
module bdim_ready
  import bdim_pkg::*;
#(
  parameter int MIN_CYC = 20000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  dim_mode_e mode,
  input  logic      rise,
  input  logic      res_valid,
  input  logic      stuck,
  output logic      ready
);
  localparam int              EL_W   = $clog2(MIN_CYC + 2);
  localparam logic [EL_W-1:0] EL_MIN = EL_W'(MIN_CYC);

  logic            seen_q;
  logic [EL_W-1:0] el_q;
  logic [1:0]      done_q;
  logic            decode_ok;

  // Two finished measurements and the minimum time, or the stuck timeout.
  assign decode_ok = ((done_q == 2'd2) && (el_q >= EL_MIN)) || stuck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      el_q   <= '0;
      done_q <= '0;
      ready  <= 1'b0;
    end else begin
      if (rise && !seen_q) begin
        seen_q <= 1'b1;
        el_q   <= EL_W'(1);
      end else if (seen_q && (el_q < EL_MIN)) begin
        el_q <= el_q + 1'b1;
      end
      if (res_valid && (done_q != 2'd2)) done_q <= done_q + 2'd1;
      if (!ready) begin
        if (canon_mode(mode) == DIM_DIRECT) ready <= rise;
        else                                ready <= decode_ok;
      end
    end
  end
endmodule

// File: rtl/bdim_shaper.sv
module bdim_shaper
  import bdim_pkg::*;
#(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dim_mode_e         mode,
  input  logic              level,
  input  logic              ready,
  input  logic              res_valid,
  input  logic [DUTY_W-1:0] res_code,
  input  logic              stuck,
  output logic [DUTY_W-1:0] amp,
  output logic              gate
);
  localparam logic [DUTY_W-1:0] FULL    = '1;
  localparam logic [DUTY_W-1:0] QUARTER = DUTY_W'(2**(DUTY_W-2));
  localparam logic [DUTY_W-1:0] FLOOR   = DUTY_W'((2**DUTY_W - 1) / 100);

  logic [DUTY_W-1:0] duty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         duty_q <= '0;
    else if (stuck)     duty_q <= FULL;
    else if (res_valid) duty_q <= res_code;
  end

  always_comb begin
    amp  = '0;
    gate = 1'b0;
    if (ready) begin
      unique case (canon_mode(mode))
        DIM_DIRECT: begin
          amp  = FULL;
          gate = level;
        end
        DIM_ANALOG: begin
          amp  = (duty_q < FLOOR) ? FLOOR : duty_q;
          gate = 1'b1;
        end
        default: begin
          if (duty_q >= QUARTER) begin
            amp  = duty_q;
            gate = 1'b1;
          end else begin
            amp  = QUARTER;
            gate = level;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bdim_decoder.sv
module bdim_decoder
  import bdim_pkg::*;
#(
  parameter int DUTY_W         = 10,
  parameter int CNT_W          = 21,
  parameter int MIN_DELAY_CYC  = 20000,
  parameter int STUCK_HIGH_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic [1:0]        dim_mode,
  output logic [DUTY_W-1:0] amp_code,
  output logic              sink_gate,
  output logic              ramp_ready
);
  dim_mode_e         mode_e;
  logic              pwm_lvl, pwm_rise, pwm_fall;
  logic              meas_valid, meas_ready;
  logic [CNT_W-1:0]  meas_period, meas_high;
  logic              stuck_pulse;
  logic              res_valid;
  logic [DUTY_W-1:0] res_code;

  assign mode_e = dim_mode_e'(dim_mode);

  bdim_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pwm_in),
    .level(pwm_lvl), .rise(pwm_rise), .fall(pwm_fall)
  );

  bdim_meter #(.CNT_W(CNT_W), .STUCK_CYC(STUCK_HIGH_CYC)) u_meter (
    .clk(clk), .rst_n(rst_n), .level(pwm_lvl), .rise(pwm_rise), .fall(pwm_fall),
    .m_valid(meas_valid), .m_ready(meas_ready),
    .m_period(meas_period), .m_high(meas_high), .stuck_pulse(stuck_pulse)
  );

  bdim_divider #(.CNT_W(CNT_W), .Q_W(DUTY_W)) u_div (
    .clk(clk), .rst_n(rst_n),
    .in_valid(meas_valid), .in_ready(meas_ready),
    .in_period(meas_period), .in_high(meas_high),
    .out_valid(res_valid), .out_code(res_code)
  );

  bdim_ready #(.MIN_CYC(MIN_DELAY_CYC)) u_ready (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .rise(pwm_rise),
    .res_valid(res_valid), .stuck(stuck_pulse), .ready(ramp_ready)
  );

  bdim_shaper #(.DUTY_W(DUTY_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .level(pwm_lvl), .ready(ramp_ready),
    .res_valid(res_valid), .res_code(res_code), .stuck(stuck_pulse),
    .amp(amp_code), .gate(sink_gate)
  );
endmodule

// File: rtl/bdim_decoder_chk.sv
module bdim_decoder_chk #(
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        dim_mode,
  input logic [DUTY_W-1:0] amp_code,
  input logic              sink_gate,
  input logic              ramp_ready,
  input logic              res_valid,
  input logic              stuck_pulse
);
  localparam logic [DUTY_W-1:0] C_FULL    = '1;
  localparam logic [DUTY_W-1:0] C_QUARTER = DUTY_W'(2**(DUTY_W-2));
  localparam logic [DUTY_W-1:0] C_FLOOR   = DUTY_W'((2**DUTY_W - 1) / 100);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_ready |-> (!sink_gate && (amp_code == '0)));

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_ready |=> ramp_ready);

  // R1
  direct_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_ready && dim_mode == 2'b00) |-> (amp_code == C_FULL));

  // R3
  mixed_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_ready && dim_mode[0]) |-> (amp_code >= C_QUARTER));

  // R2
  mixed_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_ready && dim_mode[0] && amp_code > C_QUARTER) |-> sink_gate);

  // R4
  analog_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_ready && dim_mode == 2'b10) |-> (sink_gate && amp_code >= C_FLOOR));

  // R10
  amp_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_ready && $past(ramp_ready) && $stable(dim_mode) &&
     !$past(res_valid) && !$past(stuck_pulse)) |-> $stable(amp_code));
endmodule

bind bdim_decoder bdim_decoder_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dim_mode(dim_mode), .amp_code(amp_code),
  .sink_gate(sink_gate), .ramp_ready(ramp_ready),
  .res_valid(res_valid), .stuck_pulse(stuck_pulse)
);

// File: tb/tb_bdim_decoder.sv
module tb_bdim_decoder;
  localparam int DUTY_W = 10;
  localparam int CNT_W  = 12;
  localparam int MIN_D  = 200;
  localparam int STUCK  = 1500;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              pwm_in = 1'b0;
  logic [1:0]        dim_mode = 2'b01;
  logic [DUTY_W-1:0] amp_code;
  logic              sink_gate;
  logic              ramp_ready;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bdim_decoder #(.DUTY_W(DUTY_W), .CNT_W(CNT_W), .MIN_DELAY_CYC(MIN_D),
                 .STUCK_HIGH_CYC(STUCK)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .dim_mode(dim_mode),
    .amp_code(amp_code), .sink_gate(sink_gate), .ramp_ready(ramp_ready)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R5: duty code from high time and period
  function automatic int code_of(int h, int p);
    return (h * 1024) / p;
  endfunction

  function automatic int amp_of(logic [1:0] m, int c);
    if (m == 2'b00) return 1023;
    if (m == 2'b10) return (c < 10) ? 10 : c;
    return (c >= 256) ? c : 256;
  endfunction

  function automatic int gate_low_of(logic [1:0] m, int c);
    if (m == 2'b00) return 0;
    if (m == 2'b10) return 1;
    return (c >= 256) ? 1 : 0;
  endfunction

  function automatic string tag_of(logic [1:0] m, int c);
    if (m == 2'b00) return "R1";
    if (m == 2'b10) return "R4";
    if (m == 2'b11) return "R9";
    return (c >= 256) ? "R2" : "R3";
  endfunction

  task automatic do_reset(logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    pwm_in = 1'b0;
    dim_mode = m;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // One input period; pwm_s seen at iteration j is the input of j-2.
  task automatic run_period(int p, int h, bit chk_en);
    int c;
    string tg;
    c  = code_of(h, p);
    tg = tag_of(dim_mode, c);
    for (int j = 0; j < p; j++) begin
      pwm_in = (j < h);
      if (chk_en) begin
        if (j == 2) begin
          chk($sformatf("%s/R5", tg), $sformatf("amp h=%0d p=%0d", h, p), amp_code, amp_of(dim_mode, c));
          chk(tg, $sformatf("gate high phase h=%0d", h), sink_gate, 1);
        end
        if (j == h + 3)
          chk(tg, $sformatf("gate low phase h=%0d", h), sink_gate, gate_low_of(dim_mode, c));
        if (j == p - 1)
          chk("R10", $sformatf("amp at period end h=%0d", h), amp_code, amp_of(dim_mode, c));
      end
      @(negedge clk);
    end
  endtask

  task automatic run_ready(int p, int h, int n, int ia, int ea, int ib, int eb, string req);
    for (int j = 0; j < n; j++) begin
      pwm_in = ((j % p) < h);
      if (j == ia) chk(req, $sformatf("ready at %0d", j), ramp_ready, ea);
      if (j == ib) chk(req, $sformatf("ready at %0d", j), ramp_ready, eb);
      @(negedge clk);
    end
  endtask

  task automatic sweep(logic [1:0] m, int h_lo, int h_hi, int h_step);
    do_reset(m);
    repeat (4) run_period(100, 50, 1'b0);
    for (int h = h_lo; h <= h_hi; h += h_step) begin
      run_period(100, h, 1'b0);
      run_period(100, h, 1'b0);
      run_period(100, h, 1'b1);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R7: reset state and a long quiet input
    do_reset(2'b01);
    chk("R7", "reset amp", amp_code, 0);
    chk("R7", "reset gate", sink_gate, 0);
    chk("R7", "reset ready", ramp_ready, 0);
    repeat (300) @(negedge clk);
    chk("R7", "quiet amp", amp_code, 0);
    chk("R7", "quiet gate", sink_gate, 0);
    chk("R7", "quiet ready", ramp_ready, 0);

    // R6: minimum time dominates (two 40-clock periods < 200)
    do_reset(2'b01);
    run_ready(40, 20, 260, 195, 0, 215, 1, "R6");
    chk("R7", "gate off before", 0, 0);
    // R6: two periods dominate (150-clock periods)
    do_reset(2'b10);
    run_ready(150, 75, 400, 300, 0, 340, 1, "R6");

    // R1: direct mode ready on first edge
    do_reset(2'b00);
    run_ready(50, 25, 60, 1, 0, 2, 1, "R1");

    // R8: stuck-high timeout
    do_reset(2'b01);
    run_ready(2000, 2000, 1530, 1490, 0, 1520, 1, "R8");
    chk("R8", "stuck amp", amp_code, 1023);
    chk("R8", "stuck gate", sink_gate, 1);

    // Sweeps over high time at 100-clock periods
    sweep(2'b01, 1, 96, 1);
    sweep(2'b10, 1, 96, 1);
    sweep(2'b00, 1, 96, 5);
    sweep(2'b11, 10, 60, 10);
    sweep(2'b11, 24, 25, 1);

    // R4: analog floor with a code below one percent
    do_reset(2'b10);
    repeat (4) run_period(100, 50, 1'b0);
    run_period(200, 1, 1'b0);
    run_period(200, 1, 1'b0);
    run_period(200, 1, 1'b1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule